// File: doc/BRIEF.md
# NOR Flash Page Program and Erase Array

This block models the storage behaviour of a NOR flash array. It holds the byte contents and applies the flash rules that matter to software. Programming can only pull bits from 1 down to 0. Only an erase brings bits back to 1, and it does so for a whole sector or for the entire array. Every program or erase is gated by a write-enable latch. A command channel carries the opcode and the address. A byte stream carries the program data. A registered read port lets a testbench or a neighbouring model inspect any byte. A fixed busy interval stands in for the real program and erase time.

Both the command channel and the data channel use valid/ready. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low during a data phase and during the busy interval, so a pending command waits with its fields held stable. Program data transfers on edges where `wr_valid` and `wr_ready` are both high. `wr_ready` is high only during the data phase of an accepted program. The source may leave gaps between beats. The beat that carries `wr_last` ends the program.

Opcodes on `cmd_op`: 1 sets the write-enable latch, 2 clears it, 3 programs, 4 erases one sector and 5 erases the whole array. Any other value is consumed and has no effect.

Top module: `flash_array_model`

## Requirements
- R1: After reset every byte reads 0xFF, `busy` and `wel` are 0, and `cmd_ready` is 1.
- R2: An accepted opcode 1 sets `wel` on the next cycle. An accepted opcode 2 clears it on the next cycle.
- R3: A program command (opcode 3) accepted while `wel` is 0 opens no data phase. `busy` and `wr_ready` stay 0 and no byte changes.
- R4: A programmed byte becomes the old value AND the data byte, so no bit ever goes from 0 to 1 through programming.
- R5: Beat k of a program goes to the byte whose upper address bits equal those of `cmd_addr` and whose lowest log2(PAGE_BYTES) bits equal (start offset + k) modulo PAGE_BYTES. Data that runs past the page end therefore wraps to the start of the same page.
- R6: A program may carry any length from 1 byte to a full page. The data phase ends on the beat with `wr_last` set.
- R7: A sector erase (opcode 4) accepted with `wel` at 1 sets every byte to 0xFF whose address bits above log2(SECTOR_BYTES) match those of `cmd_addr`. All other bytes keep their values.
- R8: A bulk erase (opcode 5) accepted with `wel` at 1 sets every byte of the array to 0xFF.
- R9: After the last data beat, or after an accepted erase, `busy` stays high for exactly BUSY_CYCLES cycles. `cmd_ready` is low whenever `busy` is high, and `wr_ready` is high only during a data phase.
- R10: `wel` is 0 from the first cycle after a program's last beat and from the first cycle after an accepted erase.
- R11: An erase command accepted while `wel` is 0 changes no byte and leaves `busy` at 0.
- R12: `rd_data` shows the byte at the `rd_addr` presented one clock edge earlier.
- R13: A command held valid while `cmd_ready` is low is not taken. It is taken on the first edge where `cmd_ready` is high. Program beats presented during gaps with `wr_valid` low are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | Opcode (1 set latch, 2 clear latch, 3 program, 4 sector erase, 5 bulk erase) |
| cmd_addr | input | log2(ARRAY_BYTES) | Start address for program, sector select for erase |
| wr_valid | input | 1 | Program data beat present |
| wr_ready | output | 1 | Data phase open |
| wr_data | input | 8 | Program data byte |
| wr_last | input | 1 | Final beat of the program |
| rd_addr | input | log2(ARRAY_BYTES) | Read address |
| rd_data | output | 8 | Byte read, one cycle after the address |
| busy | output | 1 | Data phase or busy interval in progress |
| wel | output | 1 | Write-enable latch |

## Verification
The bench builds the block with a 1024-byte array, 32-byte pages, 256-byte sectors and a 5-cycle busy interval. With these values a full read of the array fits between operations. Random start offsets wrap inside a page often, and four sectors let an erase be checked against neighbours that must not change. Random programs, latch commands and erases run against a byte-level model in the bench. Directed cases cover single-byte and full-page writes, rejected operations and a command that waits out the busy interval.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_WREN   = 3'd1,
    OP_WRDI   = 3'd2,
    OP_PROG   = 3'd3,
    OP_SERASE = 3'd4,
    OP_BERASE = 3'd5
  } flash_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_WAIT = 2'd2
  } flash_state_e;
endpackage

// File: rtl/flash_seq.sv
module flash_seq
  import flash_pkg::*;
#(
  parameter int BUSY_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic       wr_valid,
  input  logic       wr_last,
  output logic       cmd_ready,
  output logic       wr_ready,
  output logic       wr_fire,
  output logic       prog_start,
  output logic       erase_go,
  output logic       erase_all,
  output logic       busy,
  output logic       wel
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

  flash_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wel_q;
  logic             cmd_fire;
  flash_op_e        op;

  assign op         = flash_op_e'(cmd_op);
  assign cmd_ready  = (state_q == ST_IDLE);
  assign wr_ready   = (state_q == ST_DATA);
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign wr_fire    = wr_valid && wr_ready;
  assign prog_start = cmd_fire && wel_q && (op == OP_PROG);
  assign erase_go   = cmd_fire && wel_q && ((op == OP_SERASE) || (op == OP_BERASE));
  assign erase_all  = (op == OP_BERASE);
  assign busy       = (state_q != ST_IDLE);
  assign wel        = wel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wel_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (prog_start) begin
            state_q <= ST_DATA;
          end else if (erase_go) begin
            state_q <= ST_WAIT;
            cnt_q   <= CNT_LOAD;
            wel_q   <= 1'b0;
          end else if (cmd_fire && op == OP_WREN) begin
            wel_q <= 1'b1;
          end else if (cmd_fire && op == OP_WRDI) begin
            wel_q <= 1'b0;
          end
        end
        ST_DATA: begin
          if (wr_fire && wr_last) begin
            state_q <= ST_WAIT;
            cnt_q   <= CNT_LOAD;
            wel_q   <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_page_ptr.sv
module flash_page_ptr #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int BASE_W = ADDR_W - PAGE_W;

  logic [BASE_W-1:0] base_q;
  logic [PAGE_W-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
    end else if (load) begin
      base_q <= load_addr[ADDR_W-1:PAGE_W];
      off_q  <= load_addr[PAGE_W-1:0];
    end else if (step) begin
      off_q <= off_q + 1'b1;
    end
  end

  assign cur_addr = {base_q, off_q};
endmodule

// File: rtl/flash_store.sv
module flash_store #(
  parameter int DEPTH  = 2048,
  parameter int ADDR_W = 11,
  parameter int SECT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              erase_en,
  input  logic              erase_all,
  input  logic [ADDR_W-1:0] erase_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int NSECT = DEPTH >> SECT_W;
  localparam int SIDX_W = ADDR_W - SECT_W;

  logic [7:0]       mem [DEPTH];
  logic [NSECT-1:0] sect_hit;

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    assign sect_hit[s] = erase_en &&
                         (erase_all || (erase_addr[ADDR_W-1:SECT_W] == SIDX_W'(s)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      rd_data <= 8'hFF;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (sect_hit[i >> SECT_W]) mem[i] <= 8'hFF;
      end
      if (wr_en) mem[wr_addr] <= mem[wr_addr] & wr_data;
      rd_data <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/flash_array_model.sv
module flash_array_model #(
  parameter int ARRAY_BYTES  = 2048,
  parameter int PAGE_BYTES   = 256,
  parameter int SECTOR_BYTES = 512,
  parameter int BUSY_CYCLES  = 16,
  localparam int ADDR_W      = $clog2(ARRAY_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  input  logic              wr_last,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              wel
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int SECT_W = $clog2(SECTOR_BYTES);

  logic              wr_fire;
  logic              prog_start;
  logic              erase_go;
  logic              erase_all;
  logic [ADDR_W-1:0] prog_addr;

  flash_seq #(.BUSY_CYCLES(BUSY_CYCLES)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .wr_valid   (wr_valid),
    .wr_last    (wr_last),
    .cmd_ready  (cmd_ready),
    .wr_ready   (wr_ready),
    .wr_fire    (wr_fire),
    .prog_start (prog_start),
    .erase_go   (erase_go),
    .erase_all  (erase_all),
    .busy       (busy),
    .wel        (wel)
  );

  flash_page_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) ptr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (prog_start),
    .load_addr (cmd_addr),
    .step      (wr_fire),
    .cur_addr  (prog_addr)
  );

  flash_store #(.DEPTH(ARRAY_BYTES), .ADDR_W(ADDR_W), .SECT_W(SECT_W)) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_fire),
    .wr_addr    (prog_addr),
    .wr_data    (wr_data),
    .erase_en   (erase_go),
    .erase_all  (erase_all),
    .erase_addr (cmd_addr),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/flash_array_model_chk.sv
module flash_array_model_chk #(
  parameter int BUSY_CYCLES = 16,
  parameter int ADDR_W      = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [7:0]        wr_data,
  input logic              wr_last,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic              busy,
  input logic              wel
);
  logic cfire;
  logic [31:0] wait_cnt;
  assign cfire = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wait_cnt <= '0;
    else if (!busy)            wait_cnt <= '0;
    else if (!wr_ready)        wait_cnt <= wait_cnt + 1;
  end

  assert_wren_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfire && cmd_op == 3'd1 |=> wel);
  assert_wrdi_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfire && cmd_op == 3'd2 |=> !wel);
  assert_prog_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfire && cmd_op == 3'd3 && !wel |=> !busy && !wr_ready);
  assert_erase_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfire && (cmd_op == 3'd4 || cmd_op == 3'd5) && !wel |=> !busy);
  assert_erase_drops_wel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfire && (cmd_op == 3'd4 || cmd_op == 3'd5) && wel |=> busy && !wel);
  assert_last_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && wr_last |=> busy && !wr_ready && !wel);
  assert_data_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> busy && !cmd_ready);
  assert_busy_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !wr_ready |-> wait_cnt < BUSY_CYCLES);
  assert_cmd_stall_R13: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
endmodule

bind flash_array_model flash_array_model_chk #(
  .BUSY_CYCLES(BUSY_CYCLES), .ADDR_W(ADDR_W)
) chk_i (.*);

// File: tb/flash_array_model_tb_top.sv
module flash_array_model_tb_top;
  localparam int TA = 1024;
  localparam int TP = 32;
  localparam int TS = 256;
  localparam int TB = 5;
  localparam int AW = $clog2(TA);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [7:0]    wr_data = 8'h00;
  logic          wr_last = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          busy;
  logic          wel;

  flash_array_model #(.ARRAY_BYTES(TA), .PAGE_BYTES(TP), .SECTOR_BYTES(TS),
                      .BUSY_CYCLES(TB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .wel(wel));

  logic [7:0] model [TA];
  bit  wel_m;
  int  n_run;
  int  n_fail;
  int  last_wait;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    int bad = 0;
    int fa = 0;
    int fv = 0;
    int fe = 0;
    @(negedge clk);
    rd_addr = '0;
    for (int i = 1; i <= TA; i++) begin
      @(negedge clk);
      if (rd_data !== model[i-1]) begin
        if (bad == 0) begin fa = i - 1; fv = rd_data; fe = model[i-1]; end
        bad++;
      end
      if (i < TA) rd_addr = AW'(i);
    end
    if (bad != 0) $display("  first mismatch at address %0h", fa);
    chk(bad == 0, req, "array byte", fv, fe);
  endtask

  // ends at the negedge after the accepting edge; last_wait = stalled negedges
  task automatic send_cmd(int op, int addr);
    last_wait = 0;
    cmd_valid = 1'b1;
    cmd_op    = 3'(op);
    cmd_addr  = AW'(addr);
    while (!cmd_ready) begin last_wait++; @(negedge clk); end
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 3'd0;
  endtask

  task automatic count_busy(string req);
    int n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == TB, req, "busy cycles", n, TB);
  endtask

  task automatic set_wel(bit on);
    send_cmd(on ? 1 : 2, 0);
    wel_m = on;
    chk(wel == on, "R2", "write-enable latch", wel, on);
  endtask

  task automatic do_prog(int addr, int len, bit fixed, logic [7:0] fval, bit gaps);
    send_cmd(3, addr);
    if (!wel_m) begin
      chk(!busy && !wr_ready, "R3", "busy/ready after ungated program", {busy, wr_ready}, 0);
      return;
    end
    for (int k = 0; k < len; k++) begin
      logic [7:0] d;
      int a;
      d = fixed ? fval : 8'($urandom);
      if (gaps && $urandom_range(0, 2) == 0) begin
        wr_valid = 1'b1; wr_data = ~d; wr_valid = 1'b0;
        repeat ($urandom_range(1, 3)) @(negedge clk); // R13 gaps are not beats
      end
      wr_valid = 1'b1;
      wr_data  = d;
      wr_last  = (k == len - 1);
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
      a = (addr / TP) * TP + ((addr % TP) + k) % TP;
      model[a] = model[a] & d;
    end
    wr_valid = 1'b0;
    wr_last  = 1'b0;
    wel_m    = 1'b0;
    chk(wel == 1'b0, "R10", "latch after program", wel, 0);
    count_busy("R9");
  endtask

  task automatic do_erase(bit bulk, int addr, bit wait_busy);
    send_cmd(bulk ? 5 : 4, addr);
    if (!wel_m) begin
      chk(!busy, "R11", "busy after ungated erase", busy, 0);
      return;
    end
    for (int i = 0; i < TA; i++)
      if (bulk || (i / TS) == (addr / TS)) model[i] = 8'hFF;
    wel_m = 1'b0;
    chk(wel == 1'b0, "R10", "latch after erase", wel, 0);
    if (wait_busy) count_busy("R9");
  endtask

  initial begin
    int seedv;
    seedv = $urandom(32'd20517);
    n_run = 0; n_fail = 0; wel_m = 0;
    for (int i = 0; i < TA; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!busy && !wel && cmd_ready && !wr_ready, "R1", "reset flags",
        {busy, wel, cmd_ready, wr_ready}, 4'b0010);
    compare_all("R1");

    // R3 program without latch; R12 read latency via compare
    do_prog(5, 3, 1'b1, 8'h00, 1'b0);
    compare_all("R3");

    // R2 set and clear latch, then program refused
    set_wel(1'b1);
    set_wel(1'b0);
    do_prog(40, 2, 1'b1, 8'h00, 1'b0);
    compare_all("R3");

    // R6 single byte
    set_wel(1'b1);
    do_prog(16, 1, 1'b1, 8'hA5, 1'b0);
    compare_all("R6");

    // R4 no 0->1: 0xA5 & 0x5A = 0x00, then 0xFF leaves it 0x00
    set_wel(1'b1);
    do_prog(16, 1, 1'b1, 8'h5A, 1'b0);
    set_wel(1'b1);
    do_prog(16, 1, 1'b1, 8'hFF, 1'b0);
    compare_all("R4");

    // R5 wrap inside page 2
    set_wel(1'b1);
    do_prog(TP * 2 + TP - 3, 8, 1'b0, 8'h00, 1'b1);
    compare_all("R5");

    // R6 full page starting mid page
    set_wel(1'b1);
    do_prog(TP * 9 + 7, TP, 1'b0, 8'h00, 1'b1);
    compare_all("R6");

    // R11 erase without latch
    do_erase(1'b0, 20, 1'b1);
    compare_all("R11");

    // R7 sector 1 erase only; fill sector 1 and 2 first
    set_wel(1'b1);
    do_prog(TS + 4, TP, 1'b0, 8'h00, 1'b0);
    set_wel(1'b1);
    do_prog(TS * 2 + 4, TP, 1'b0, 8'h00, 1'b0);
    set_wel(1'b1);
    do_erase(1'b0, TS + 100, 1'b1);
    compare_all("R7");

    // R13 command held through busy interval
    set_wel(1'b1);
    do_erase(1'b0, 0, 1'b0);
    send_cmd(1, 0);
    wel_m = 1'b1;
    chk(last_wait == TB, "R13", "stalled cycles", last_wait, TB);
    chk(wel == 1'b1, "R13", "latch after stalled command", wel, 1);
    compare_all("R7");

    // random mix
    for (int n = 0; n < 45; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r <= 2)      set_wel(1'b1);
      else if (r == 3) set_wel(1'b0);
      else if (r <= 7) do_prog($urandom_range(0, TA - 1), $urandom_range(1, TP),
                               1'b0, 8'h00, 1'b1);
      else if (r == 8) do_erase(1'b0, $urandom_range(0, TA - 1), 1'b1);
      else             do_erase($urandom_range(0, 3) == 0, $urandom_range(0, TA - 1), 1'b1);
      compare_all("R4");
    end

    // R8 bulk erase after dirtying every sector
    for (int s = 0; s < TA / TS; s++) begin
      set_wel(1'b1);
      do_prog(s * TS + 3, 5, 1'b1, 8'h0F, 1'b0);
    end
    set_wel(1'b1);
    do_erase(1'b1, 0, 1'b1);
    compare_all("R8");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule